// File: doc/BRIEF.md
# SD Command Issue Engine

This block sends a single SD command on the CMD line and captures the card's reply into response registers. Software first loads a 32-bit argument. It then writes a 16-bit command word that carries a "go" bit. The engine builds a 48-bit command frame, including its CRC7, and shifts it out one bit per clock with the output enable held high. It then releases the line and, if a reply is expected, waits for a short (48-bit) or long (136-bit) reply, or for none.

The go bit is the completion handshake. It stays set while the command is in flight, and the engine clears it when the command ends. An error raises a fail bit in the command register together with a matching sticky status flag, which software clears by writing one. Clock division, the data path and busy signalling are outside the block. The read-data, write-data and busy-wait bits are only stored.

The register port is a plain single-cycle write strobe with combinational read data. There is no back-pressure. A command write that arrives while a command is in flight is dropped.

Top module: `sd_cmd_engine`

## Requirements
- R1: The command register is byte offset 0x00. Its index is in bits 5:0, read-data in bit 6, write-data in bit 7, long-response in bit 9, no-response in bit 10, busy-wait in bit 11, fail in bit 14 and go in bit 15. Any other bits read as zero. When no command is in flight, a write stores these fields, clears the fail bit, and starts a command if bit 15 is set. A command that ends without error reads back with bit 15 clear, bit 14 clear and the stored fields kept.
- R2: A started command drives exactly 48 bits, MSB first, one per clock, with cmd_oe high. The bits are: 0, then 1, then the 6-bit index, then the 32-bit argument, then the CRC7, then 1.
- R3: The CRC7 in the command frame uses the polynomial x^7+x^3+1 and a zero initial value. It covers the first 40 frame bits.
- R4: A command with the no-response bit set completes right after its end bit, with no fail bit and no status flag set.
- R5: A short reply loads its 32 bits between the index and the CRC into response word 0 (offset 0x10). Words 1 to 3 keep their values.
- R6: A long reply is 136 bits. Its 120 bits between the 8-bit header and the CRC load response words 0 to 3 (offsets 0x10 to 0x1C), right-aligned, with word 3 bits 31:24 zero. Its CRC is neither checked nor stored.
- R7: If a short reply's received CRC7, computed over its first 40 bits, does not match, the engine sets the fail bit and status bit 4 (0x10).
- R8: If no start bit (0) is sampled within RSP_WAIT cycles after the line is released, the engine sets the fail bit and status bit 6 (0x40). A start bit in the last of those cycles is still accepted.
- R9: The status register is at offset 0x20. Writing a one to bit 4 or bit 6 clears that flag. Writing a zero leaves it unchanged.
- R10: A command-register write while the go bit is set is ignored. The fields are unchanged and no second frame is sent.
- R11: The argument register at offset 0x04 is a full 32-bit read/write register.
- R12: After reset, all registers read zero, cmd_oe is low and cmd_out is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the CMD bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line sampled value |

## Verification
The bench builds the engine with RSP_WAIT=8. This keeps a sweep of reply delays from zero to two cycles past the window short. The sweep covers both the last accepted delay and the first one that times out. Each command frame is captured from the line and compared with a frame and CRC7 that the bench computes itself, across several index and argument patterns. Replies with good and corrupted CRCs, long replies and ignored writes follow.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_FRAME_BITS = 48;
  localparam int SHORT_RSP_BITS = 48;
  localparam int LONG_RSP_BITS  = 136;
  localparam int CRC_SPAN_BITS  = 40;

  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_t;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_span(input logic [CRC_SPAN_BITS-1:0] d);
    logic [6:0] c;
    c = 7'h00;
    for (int i = CRC_SPAN_BITS - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_tx.sv
module sdc_tx
  import sdc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CMD_FRAME_BITS-1:0] frame,
  output logic                      line_out,
  output logic                      line_oe,
  output logic                      last_bit
);
  localparam int CW = $clog2(CMD_FRAME_BITS);

  logic [CMD_FRAME_BITS-1:0] sr_q;
  logic [CW-1:0]             cnt_q;
  logic                      busy_q;

  assign line_out = busy_q ? sr_q[CMD_FRAME_BITS-1] : 1'b1;
  assign line_oe  = busy_q;
  assign last_bit = busy_q && (cnt_q == CW'(CMD_FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sr_q   <= frame;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sr_q <= {sr_q[CMD_FRAME_BITS-2:0], 1'b1};
      if (last_bit) busy_q <= 1'b0;
      else          cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2
  tx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CW'(CMD_FRAME_BITS - 1)));
endmodule

// File: rtl/sdc_rx.sv
module sdc_rx
  import sdc_pkg::*;
#(
  parameter int RSP_WAIT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         long_rsp,
  input  logic         line_in,
  output logic         fin,
  output logic         timed_out,
  output logic         crc_bad,
  output logic [127:0] frame
);
  localparam int WW = $clog2(RSP_WAIT + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_state_t;

  rx_state_t    st_q;
  logic [WW-1:0] wcnt_q;
  logic [7:0]    bcnt_q;
  logic [6:0]    crc_q;
  logic [127:0]  sr_q;
  logic          long_q, done_q, to_q;
  logic [7:0]    last_idx;

  assign last_idx  = long_q ? 8'(LONG_RSP_BITS - 1) : 8'(SHORT_RSP_BITS - 1);
  assign frame     = sr_q;
  assign fin       = done_q | to_q;
  assign timed_out = to_q;
  assign crc_bad   = done_q && !long_q && (crc_q != sr_q[7:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      wcnt_q <= '0;
      bcnt_q <= '0;
      crc_q  <= '0;
      sr_q   <= '0;
      long_q <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (arm) begin
          st_q   <= RX_WAIT;
          wcnt_q <= '0;
          long_q <= long_rsp;
          crc_q  <= '0;
        end
        RX_WAIT: begin
          if (!line_in) begin
            st_q   <= RX_RECV;
            bcnt_q <= 8'd1;
            sr_q   <= {sr_q[126:0], 1'b0};
          end else if (wcnt_q == WW'(RSP_WAIT - 1)) begin
            st_q <= RX_IDLE;
            to_q <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        RX_RECV: begin
          sr_q <= {sr_q[126:0], line_in};
          if (bcnt_q < 8'(CRC_SPAN_BITS)) crc_q <= crc7_step(crc_q, line_in);
          if (bcnt_q == last_idx) begin
            st_q   <= RX_IDLE;
            done_q <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  // R8
  rx_single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && to_q));
  // R8
  rx_wait_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_WAIT) |-> (wcnt_q < WW'(RSP_WAIT)));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int RSP_WAIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  localparam logic [15:0] CMD_KEEP_MASK = 16'h8EFF;
  localparam int B_GO = 15, B_FAIL = 14, B_NORSP = 10, B_LONG = 9;

  logic [15:0]  cmd_q;
  logic [31:0]  arg_q;
  logic [127:0] resp_q;
  logic         sts_to_q, sts_crc_q;
  phase_t       ph_q;

  logic wr_cmd, wr_arg, wr_sts, start;
  logic [CMD_FRAME_BITS-1:0] tx_frame;
  logic [CRC_SPAN_BITS-1:0]  tx_head;
  logic tx_last, rx_arm, rx_fin, rx_to, rx_crc_bad;
  logic [127:0] rx_frame;

  assign wr_cmd = reg_wr && (reg_addr[5:2] == 4'h0);
  assign wr_arg = reg_wr && (reg_addr[5:2] == 4'h1);
  assign wr_sts = reg_wr && (reg_addr[5:2] == 4'h8);
  assign start  = wr_cmd && !cmd_q[B_GO] && reg_wdata[B_GO];

  assign tx_head  = {2'b01, reg_wdata[5:0], arg_q};
  assign tx_frame = {tx_head, crc7_span(tx_head), 1'b1};
  assign rx_arm   = tx_last && !cmd_q[B_NORSP];

  sdc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(start), .frame(tx_frame),
    .line_out(cmd_out), .line_oe(cmd_oe), .last_bit(tx_last)
  );

  sdc_rx #(.RSP_WAIT(RSP_WAIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(rx_arm), .long_rsp(cmd_q[B_LONG]),
    .line_in(cmd_in), .fin(rx_fin), .timed_out(rx_to), .crc_bad(rx_crc_bad),
    .frame(rx_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      arg_q     <= '0;
      resp_q    <= '0;
      sts_to_q  <= 1'b0;
      sts_crc_q <= 1'b0;
      ph_q      <= PH_IDLE;
    end else begin
      if (wr_arg) arg_q <= reg_wdata;
      if (wr_cmd && !cmd_q[B_GO]) cmd_q <= reg_wdata[15:0] & CMD_KEEP_MASK;
      if (wr_sts) begin
        if (reg_wdata[6]) sts_to_q  <= 1'b0;
        if (reg_wdata[4]) sts_crc_q <= 1'b0;
      end
      unique case (ph_q)
        PH_IDLE: if (start) ph_q <= PH_TX;
        PH_TX: if (tx_last) begin
          if (cmd_q[B_NORSP]) begin
            cmd_q[B_GO] <= 1'b0;
            ph_q        <= PH_IDLE;
          end else begin
            ph_q <= PH_RX;
          end
        end
        PH_RX: if (rx_fin) begin
          cmd_q[B_GO] <= 1'b0;
          ph_q        <= PH_IDLE;
          if (rx_to) begin
            cmd_q[B_FAIL] <= 1'b1;
            sts_to_q      <= 1'b1;
          end else begin
            if (cmd_q[B_LONG]) resp_q <= {8'h00, rx_frame[127:8]};
            else               resp_q[31:0] <= rx_frame[39:8];
            if (rx_crc_bad) begin
              cmd_q[B_FAIL] <= 1'b1;
              sts_crc_q     <= 1'b1;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr[5:2])
      4'h0:    reg_rdata = {16'h0000, cmd_q};
      4'h1:    reg_rdata = arg_q;
      4'h4:    reg_rdata = resp_q[31:0];
      4'h5:    reg_rdata = resp_q[63:32];
      4'h6:    reg_rdata = resp_q[95:64];
      4'h7:    reg_rdata = resp_q[127:96];
      4'h8:    reg_rdata = {25'h0, sts_to_q, 1'b0, sts_crc_q, 4'h0};
      default: reg_rdata = 32'h0;
    endcase
  end

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd_q[B_GO]) |=> $stable(cmd_q[11:0]));
  // R4
  idle_line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[B_GO] |-> !cmd_oe);
  // R1
  fail_at_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_q[B_FAIL]) |-> $fell(cmd_q[B_GO]));
  // R9
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && reg_wdata[6] && !rx_fin) |=> !sts_to_q);
endmodule

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cmd_out, cmd_oe;
  logic cmd_in = 1'b1;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sd_cmd_engine #(.RSP_WAIT(RW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] r = 7'h00;
    for (int i = 39; i >= 0; i--) begin
      logic top = r[6] ^ d[i];
      r = {r[5:0], 1'b0};
      if (top) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic issue(input logic [15:0] w, output logic [47:0] fr, output int n);
    wr(6'h00, {16'h0, w});
    n = 0; fr = '0;
    while (cmd_oe && n < 60) begin
      fr = {fr[46:0], cmd_out};
      n++;
      @(negedge clk);
    end
  endtask

  task automatic drive(input logic [135:0] f, input int len, input int d);
    for (int i = 0; i < d; i++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int i = 0; i < len; i++) begin cmd_in = f[len-1-i]; @(negedge clk); end
    cmd_in = 1'b1;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(6'h00, v);
      if (!v[15]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] c, input bit bad);
    logic [39:0] h = {2'b00, idx, c};
    return {h, ref_crc(h) ^ (bad ? 7'h01 : 7'h00), 1'b1};
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    logic [47:0] fr;
    logic [119:0] lc;
    logic [127:0] lr;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int r = 0; r < 9; r++) begin
      if (r == 2 || r == 3) continue;
      rd(6'(r * 4), v);
      chk(v == 0, "R12 reg", v, 0);
    end
    chk(!cmd_oe && cmd_out, "R12 line", {cmd_oe, cmd_out}, 2'b01);

    // R11 argument register
    foreach (a_pat[i]) ;
    for (int i = 0; i < 4; i++) begin
      a = (i == 0) ? 32'hFFFF_FFFF : (i == 1) ? 32'h0 : (i == 2) ? 32'hA5A5_5A5A : 32'h1234_5678;
      wr(6'h04, a);
      rd(6'h04, v);
      chk(v == a, "R11 arg", v, a);
    end

    // R2 R3 R4 R1: no-response commands over index/argument patterns
    for (int i = 0; i < 5; i++) begin
      logic [5:0] idx;
      logic [39:0] h;
      idx = (i == 0) ? 6'd0 : (i == 1) ? 6'd1 : (i == 2) ? 6'd17 : (i == 3) ? 6'd40 : 6'd63;
      a = (32'(idx) * 32'h0102_0305) ^ 32'hC300_0000;
      wr(6'h04, a);
      issue(16'h8400 | 16'(idx), fr, n);
      h = {2'b01, idx, a};
      chk(n == 48, "R2 frame length", n, 48);
      chk(fr == {h, ref_crc(h), 1'b1}, "R2 R3 frame bits", fr, {h, ref_crc(h), 1'b1});
      wait_done();
      rd(6'h00, v);
      chk(v == (32'h0400 | 32'(idx)), "R4 R1 completion", v, 32'h0400 | 32'(idx));
      rd(6'h20, v);
      chk(v == 0, "R4 status", v, 0);
    end

    // R5 R8 R9: short reply, delay swept across the wait window
    for (int d = 0; d <= RW + 1; d++) begin
      logic [31:0] c = 32'h9000_0000 + 32'(d) * 32'h1111;
      wr(6'h04, 32'h0000_00AA);
      issue(16'h800D, fr, n);
      drive({88'h0, short_rsp(6'd13, c, 1'b0)}, 48, d);
      wait_done();
      rd(6'h00, v);
      if (d < RW) begin
        chk(v == 32'h000D, "R8 accepted delay", v, 32'h000D);
        rd(6'h10, v);
        chk(v == c, "R5 short word0", v, c);
        rd(6'h20, v);
        chk(v == 0, "R8 no timeout", v, 0);
      end else begin
        chk(v == 32'h400D, "R8 timeout fail", v, 32'h400D);
        rd(6'h20, v);
        chk(v == 32'h40, "R8 timeout flag", v, 32'h40);
        wr(6'h20, 32'h10);
        rd(6'h20, v);
        chk(v == 32'h40, "R9 zero write keeps", v, 32'h40);
        wr(6'h20, 32'h40);
        rd(6'h20, v);
        chk(v == 0, "R9 clear", v, 0);
      end
    end

    // R7 bad CRC on short reply
    issue(16'h8007, fr, n);
    drive({88'h0, short_rsp(6'd7, 32'hDEAD_BEEF, 1'b1)}, 48, 2);
    wait_done();
    rd(6'h00, v);
    chk(v == 32'h4007, "R7 fail bit", v, 32'h4007);
    rd(6'h20, v);
    chk(v == 32'h10, "R7 crc flag", v, 32'h10);
    wr(6'h20, 32'h50);
    rd(6'h20, v);
    chk(v == 0, "R7 R9 cleared", v, 0);

    // R6 long reply with arbitrary CRC field
    lc = {30'h2AAA_5555, 30'h1234_5678, 30'h0FED_CBA9, 30'h3C3C_C3C3};
    issue(16'h8202, fr, n);
    drive({2'b00, 6'h3F, lc, 7'h55, 1'b1}, 136, 3);
    wait_done();
    rd(6'h00, v);
    chk(v == 32'h0202, "R6 no crc check", v, 32'h0202);
    lr = {8'h00, lc};
    for (int w = 0; w < 4; w++) begin
      rd(6'(16 + 4 * w), v);
      chk(v == lr[32*w +: 32], "R6 long word", v, lr[32*w +: 32]);
    end

    // R5 short reply leaves words 1..3
    issue(16'h8003, fr, n);
    drive({88'h0, short_rsp(6'd3, 32'h0BAD_F00D, 1'b0)}, 48, 1);
    wait_done();
    rd(6'h10, v);
    chk(v == 32'h0BAD_F00D, "R5 word0", v, 32'h0BAD_F00D);
    for (int w = 1; w < 4; w++) begin
      rd(6'(16 + 4 * w), v);
      chk(v == lr[32*w +: 32], "R5 upper words kept", v, lr[32*w +: 32]);
    end

    // R10 write while in flight
    wr(6'h00, 32'h8405);
    repeat (5) @(negedge clk);
    wr(6'h00, 32'h8209);
    wait_done();
    rd(6'h00, v);
    chk(v == 32'h0405, "R10 fields kept", v, 32'h0405);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (cmd_oe) n++;
      @(negedge clk);
    end
    chk(n == 0, "R10 no second frame", n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
  int a_pat[1];
endmodule